// File: doc/BRIEF.md
# Serial Flash Byte Read Engine

This block fetches bytes from a serial NOR flash, one byte per command, under control of a small byte-wide register file. Software picks the read opcode, the number of lines used for the address and for the returned data, whether dummy clocks are inserted, and whether the address is 24 or 32 bits wide. It then loads a start address and issues the read command. The engine frames a complete transaction with chip select: the opcode on one line, then the address, then optional dummy clocks, then eight data bits. It places the received byte in a data register and clears the busy indication.

After every completed read the stored address advances by one. Repeated read commands therefore stream through consecutive flash bytes without software rewriting the address. The serial clock runs at half the system clock in SPI mode 0. The engine drives outgoing bits while the clock is low, and both sides sample on its rising edge.

Top module: `sflash_rd_engine`

## Requirements
- R1: After reset `spi_cs_n` is 1, `spi_sck` is 0, `spi_io_oe` is 0 and every register reads back as 0x00.
- R2: A write of 0x81 to the command register (offset 0x00) while idle starts one byte read. The command register then reads 0x01 (0x81 masked with 0x1f) until the byte is ready and 0x00 afterwards. Writes of any other value, and writes made while a read is running, start nothing.
- R3: The opcode is sent first, MSB first, on IO0 only. It is taken from opcode slot A (offset 0x24) unless quad data is enabled (mode bit 2), in which case it comes from slot B (offset 0x28).
- R4: The mode register (offset 0x04) bit 4 selects 32 address bits when set and the low 24 address bits when clear. The address is sent MSB first.
- R5: Address lines are 4 when mode bit 3 is set, otherwise 2 when mode bit 1 is set, otherwise 1. With L lines, each serial clock carries L address bits, and IO[L-1] holds the most significant of them. `spi_io_oe` equals the mask of the L lines during the address and 0b0001 during the opcode.
- R6: Bit 0 of the configuration register (offset 0x08) inserts 8 dummy serial clocks between address and data, with no line driven. The total number of rising serial clock edges per frame is 8 + address bits / L + dummies + 8 / D.
- R7: Data lines D are 4 when mode bit 2 is set, otherwise 2 when mode bit 0 is set, otherwise 1. Single-line data is taken from IO1. With D lines, IO[D-1] carries the most significant bit of each group. Data arrives MSB first and is sampled on rising edges.
- R8: The read-data register (offset 0x0C) holds the received byte from the end of a read until the next read ends.
- R9: The address is held in byte registers at offsets 0x10 (bits 7:0), 0x14 (15:8), 0x18 (23:16) and 0x20 (31:24). After each read it increases by one as a 32-bit value, with carries across bytes and wrap from 0xFFFFFFFF to 0.
- R10: `spi_cs_n` stays low for exactly one whole frame and returns high between commands. While it is high, `spi_sck` is 0 and no line is driven. While it is low, `spi_sck` toggles every system clock.
- R11: Writes to the address byte registers while a read is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_io_out | output | 4 | Values driven onto IO0..IO3 |
| spi_io_oe | output | 4 | Per-line output enable |
| spi_io_in | input | 4 | Values sampled from IO0..IO3 |

## Verification
The bench builds the engine with its default of 8 dummy clocks. A small flash model in the bench decodes the opcode and address from the pins and returns a byte computed from that address. The bench sweeps all 16 patterns of the four lane-enable bits against both address widths and both fast-read settings, 64 configurations in all. This covers every precedence case between the dual and quad enables and both opcode slots. Each configuration performs two back-to-back reads from an address ending in 0xFE, so the auto-increment must carry into the next byte. Further cases cover the 32-bit wrap, rejected command values, a second start issued while busy, and address writes during a transfer.

// File: rtl/sfre_pkg.sv
// Shared constants and types for the serial flash byte read engine.
// Assumes a byte-wide register bus with 8-bit offsets.
package sfre_pkg;
    localparam int OPC_W      = 8;
    localparam int ADDR_MAX_W = 32;
    localparam int DATA_W     = 8;
    localparam int FRAME_W    = OPC_W + ADDR_MAX_W;

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_MODE  = 8'h04;
    localparam logic [7:0] OFS_CFG   = 8'h08;
    localparam logic [7:0] OFS_RDATA = 8'h0C;
    localparam logic [7:0] OFS_AB0   = 8'h10;
    localparam logic [7:0] OFS_AB1   = 8'h14;
    localparam logic [7:0] OFS_AB2   = 8'h18;
    localparam logic [7:0] OFS_AB3   = 8'h20;
    localparam logic [7:0] OFS_OPA   = 8'h24;
    localparam logic [7:0] OFS_OPB   = 8'h28;

    localparam logic [7:0] CMD_READ  = 8'h81;
    localparam logic [7:0] BUSY_MASK = 8'h1F;

    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADR, ST_DUM, ST_DAT, ST_FIN
    } seq_state_e;

    // Settings handed to the sequencer at command start.
    typedef struct packed {
        logic [OPC_W-1:0]      opcode;
        logic [ADDR_MAX_W-1:0] addr;
        logic [1:0]            alog;   // log2 of address lines
        logic [1:0]            dlog;   // log2 of data lines
        logic                  wide;   // 32-bit address
        logic                  fast;   // insert dummy clocks
    } xfer_cfg_t;

    // Line count as log2: quad wins over dual, else single.
    function automatic logic [1:0] lane_log(input logic quad, input logic dual);
        return quad ? 2'd2 : (dual ? 2'd1 : 2'd0);
    endfunction
endpackage

// File: rtl/sfre_regs.sv
// Register file of the read engine: mode, config, opcode slots, address
// bytes, read data and the command/busy register.
// Assumes: one access per cycle, reads are combinational on reg_addr.
module sfre_regs
    import sfre_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [7:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               done,
    input  logic [DATA_W-1:0]  done_byte,
    output logic               start,
    output logic               busy,
    output logic [DATA_W-1:0]  last_byte,
    output xfer_cfg_t          cfg
);
    logic [4:0]            mode_q;
    logic                  fast_q;
    logic [OPC_W-1:0]      opa_q;
    logic [OPC_W-1:0]      opb_q;
    logic [ADDR_MAX_W-1:0] addr_q;
    logic [DATA_W-1:0]     rdata_q;
    logic                  busy_q;

    assign start     = we && (addr == OFS_CMD) && (wdata == CMD_READ) && !busy_q;
    assign busy      = busy_q;
    assign last_byte = rdata_q;

    // Register updates from the bus and from read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            fast_q  <= 1'b0;
            opa_q   <= '0;
            opb_q   <= '0;
            addr_q  <= '0;
            rdata_q <= '0;
            busy_q  <= 1'b0;
        end else begin
            if (start) begin
                busy_q <= 1'b1;
            end
            if (done) begin
                busy_q  <= 1'b0;
                rdata_q <= done_byte;
                addr_q  <= addr_q + 1'b1;
            end
            if (we) begin
                case (addr)
                    OFS_MODE: mode_q <= wdata[4:0];
                    OFS_CFG:  fast_q <= wdata[0];
                    OFS_OPA:  opa_q  <= wdata;
                    OFS_OPB:  opb_q  <= wdata;
                    OFS_AB0:  if (!busy_q) addr_q[7:0]   <= wdata;
                    OFS_AB1:  if (!busy_q) addr_q[15:8]  <= wdata;
                    OFS_AB2:  if (!busy_q) addr_q[23:16] <= wdata;
                    OFS_AB3:  if (!busy_q) addr_q[31:24] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            OFS_CMD:   rdata = busy_q ? (CMD_READ & BUSY_MASK) : 8'h00;
            OFS_MODE:  rdata = {3'b000, mode_q};
            OFS_CFG:   rdata = {7'b0, fast_q};
            OFS_RDATA: rdata = rdata_q;
            OFS_AB0:   rdata = addr_q[7:0];
            OFS_AB1:   rdata = addr_q[15:8];
            OFS_AB2:   rdata = addr_q[23:16];
            OFS_AB3:   rdata = addr_q[31:24];
            OFS_OPA:   rdata = opa_q;
            OFS_OPB:   rdata = opb_q;
            default:   rdata = 8'h00;
        endcase
    end

    // Transfer settings decoded from the mode and config registers.
    always_comb begin
        cfg.opcode = mode_q[2] ? opb_q : opa_q;
        cfg.addr   = addr_q;
        cfg.alog   = lane_log(mode_q[3], mode_q[1]);
        cfg.dlog   = lane_log(mode_q[2], mode_q[0]);
        cfg.wide   = mode_q[4];
        cfg.fast   = fast_q;
    end
endmodule

// File: rtl/sfre_seq.sv
// Frame sequencer: opcode, address, dummy and data phases on a serial clock
// at half the system clock (mode 0). Settings are latched at start.
// Assumes DUMMY_SCK >= 1.
module sfre_seq
    import sfre_pkg::*;
#(
    parameter int DUMMY_SCK = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  xfer_cfg_t  cfg,
    output logic       cs_n,
    output logic       sck,
    output logic [3:0] io_out,
    output logic [3:0] io_oe,
    output logic       cap_en,
    output logic       cap_clr,
    output logic       done,
    output logic [1:0] dlog
);
    localparam int MAXCNT = (DUMMY_SCK > ADDR_MAX_W) ? DUMMY_SCK : ADDR_MAX_W;
    localparam int CNT_W  = $clog2(MAXCNT + 1);

    seq_state_e         state_q;
    logic               sck_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] tx_q;
    logic [1:0]         alog_q;
    logic [1:0]         dlog_q;
    logic               wide_q;
    logic               fast_q;
    logic [CNT_W-1:0]   adr_last;
    logic [CNT_W-1:0]   dat_last;

    // Last count value of the address and data phases.
    always_comb begin
        adr_last = CNT_W'(((wide_q ? ADDR_MAX_W : 24) >> alog_q) - 1);
        dat_last = CNT_W'((DATA_W >> dlog_q) - 1);
    end

    // Phase, clock and shift register progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sck_q   <= 1'b0;
            cnt_q   <= '0;
            tx_q    <= '0;
            alog_q  <= '0;
            dlog_q  <= '0;
            wide_q  <= 1'b0;
            fast_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_OPC;
                        sck_q   <= 1'b0;
                        cnt_q   <= CNT_W'(OPC_W - 1);
                        tx_q    <= cfg.wide ? {cfg.opcode, cfg.addr}
                                            : {cfg.opcode, cfg.addr[23:0], 8'h00};
                        alog_q  <= cfg.alog;
                        dlog_q  <= cfg.dlog;
                        wide_q  <= cfg.wide;
                        fast_q  <= cfg.fast;
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q <= 1'b0;
                        cnt_q <= cnt_q - 1'b1;
                        if (state_q == ST_OPC) begin
                            tx_q <= tx_q << 1;
                        end else if (state_q == ST_ADR) begin
                            tx_q <= tx_q << (1 << alog_q);
                        end
                        if (cnt_q == '0) begin
                            case (state_q)
                                ST_OPC: begin
                                    state_q <= ST_ADR;
                                    cnt_q   <= adr_last;
                                end
                                ST_ADR: begin
                                    state_q <= fast_q ? ST_DUM : ST_DAT;
                                    cnt_q   <= fast_q ? CNT_W'(DUMMY_SCK - 1) : dat_last;
                                end
                                ST_DUM: begin
                                    state_q <= ST_DAT;
                                    cnt_q   <= dat_last;
                                end
                                default: state_q <= ST_FIN;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Pin drive for the opcode and address phases.
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (state_q == ST_OPC) begin
            io_out[0] = tx_q[FRAME_W-1];
            io_oe     = 4'b0001;
        end else if (state_q == ST_ADR) begin
            case (alog_q)
                2'd0: begin
                    io_out[0] = tx_q[FRAME_W-1];
                    io_oe     = 4'b0001;
                end
                2'd1: begin
                    io_out[1:0] = tx_q[FRAME_W-1 -: 2];
                    io_oe       = 4'b0011;
                end
                default: begin
                    io_out = tx_q[FRAME_W-1 -: 4];
                    io_oe  = 4'b1111;
                end
            endcase
        end
    end

    assign cs_n    = (state_q == ST_IDLE) || (state_q == ST_FIN);
    assign sck     = sck_q;
    assign cap_en  = (state_q == ST_DAT) && !sck_q;
    assign cap_clr = start && (state_q == ST_IDLE);
    assign done    = (state_q == ST_FIN);
    assign dlog    = dlog_q;
endmodule

// File: rtl/sfre_capture.sv
// Data capture: shifts 1, 2 or 4 bits per rising serial clock into a byte.
// Single-line data arrives on IO1; wider modes put the MSB on the top line.
module sfre_capture
    import sfre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [1:0]        dlog,
    input  logic [3:0]        io_in,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] rx_q;

    // Shift register fed from the selected lines.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rx_q <= '0;
        end else if (en) begin
            case (dlog)
                2'd0:    rx_q <= {rx_q[DATA_W-2:0], io_in[1]};
                2'd1:    rx_q <= {rx_q[DATA_W-3:0], io_in[1:0]};
                default: rx_q <= {rx_q[DATA_W-5:0], io_in[3:0]};
            endcase
        end
    end

    assign rx_byte = rx_q;
endmodule

// File: rtl/sflash_rd_engine.sv
// Top of the serial flash byte read engine: register file, frame sequencer
// and data capture. One byte per command; the address auto-advances.
module sflash_rd_engine
    import sfre_pkg::*;
#(
    parameter int DUMMY_SCK = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       spi_cs_n,
    output logic       spi_sck,
    output logic [3:0] spi_io_out,
    output logic [3:0] spi_io_oe,
    input  logic [3:0] spi_io_in
);
    xfer_cfg_t         cfg_w;
    logic              start_w;
    logic              busy_w;
    logic              done_w;
    logic              cap_en_w;
    logic              cap_clr_w;
    logic [1:0]        dlog_w;
    logic [DATA_W-1:0] rx_byte_w;
    logic [DATA_W-1:0] rd_byte_w;
    logic [31:0]       cur_addr_w;

    assign cur_addr_w = cfg_w.addr;

    sfre_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .done      (done_w),
        .done_byte (rx_byte_w),
        .start     (start_w),
        .busy      (busy_w),
        .last_byte (rd_byte_w),
        .cfg       (cfg_w)
    );

    sfre_seq #(.DUMMY_SCK(DUMMY_SCK)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .cfg     (cfg_w),
        .cs_n    (spi_cs_n),
        .sck     (spi_sck),
        .io_out  (spi_io_out),
        .io_oe   (spi_io_oe),
        .cap_en  (cap_en_w),
        .cap_clr (cap_clr_w),
        .done    (done_w),
        .dlog    (dlog_w)
    );

    sfre_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cap_clr_w),
        .en      (cap_en_w),
        .dlog    (dlog_w),
        .io_in   (spi_io_in),
        .rx_byte (rx_byte_w)
    );
endmodule

// File: rtl/sfre_checker.sv
// Protocol and register-hold checks for the read engine, bound to the top.
module sfre_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        sck,
    input logic [3:0]  oe,
    input logic        busy,
    input logic [31:0] addr,
    input logic [7:0]  rd_byte
);
    AST_SCK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);  // R10
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (oe == 4'b0000));  // R10
    AST_SCK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !$past(cs_n)) |-> (sck != $past(sck)));  // R10
    AST_BUSY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);  // R2
    AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (oe == 4'b0000) || (oe == 4'b0001) || (oe == 4'b0011) || (oe == 4'b1111));  // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr));  // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_byte));  // R8
endmodule

bind sflash_rd_engine sfre_checker u_sfre_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .oe      (spi_io_oe),
    .busy    (busy_w),
    .addr    (cur_addr_w),
    .rd_byte (rd_byte_w)
);

// File: tb/sflash_rd_engine_bench.sv
`timescale 1ns/1ps
module sflash_rd_engine_bench;
    localparam logic [7:0] A_CMD = 8'h00, A_MODE = 8'h04, A_CFG = 8'h08, A_RD = 8'h0C;
    localparam logic [7:0] A_B0 = 8'h10, A_B1 = 8'h14, A_B2 = 8'h18, A_B3 = 8'h20;
    localparam logic [7:0] A_OPA = 8'h24, A_OPB = 8'h28;
    localparam int DUMMIES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic spi_cs_n, spi_sck;
    logic [3:0] spi_io_out, spi_io_oe;
    logic [3:0] spi_io_in = 4'h0;

    always #2 clk = ~clk;

    sflash_rd_engine u_sflash_rd_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
        .spi_io_in(spi_io_in)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Model configuration, set by the stimulus before each frame.
    int  m_al = 1;
    int  m_dl = 1;
    bit  m_wide = 0;
    bit  m_fast = 0;

    // Flash model state.
    int          rises = 0;
    int          sess_rises = 0;
    int          cs_falls = 0;
    logic [7:0]  got_op = 8'h00;
    logic [31:0] got_addr = 32'h0;

    function automatic logic [7:0] mem(input logic [31:0] a);
        return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ a[31:24] ^ 8'h6B;
    endfunction

    function automatic int pre_tx();
        return 8 + (m_wide ? 32 : 24) / m_al;
    endfunction

    function automatic int pre_all();
        return pre_tx() + (m_fast ? DUMMIES : 0);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Frame start and opcode/address collection on rising serial clock.
    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (!spi_sck) begin
            rises = 0;
            got_op = 8'h00;
            got_addr = 32'h0;
            cs_falls++;
        end else if (!spi_cs_n) begin
            if (rises < 8) begin
                got_op = {got_op[6:0], spi_io_out[0]};
            end else if (rises < pre_tx()) begin
                case (m_al)
                    1: got_addr = {got_addr[30:0], spi_io_out[0]};
                    2: got_addr = {got_addr[29:0], spi_io_out[1:0]};
                    default: got_addr = {got_addr[27:0], spi_io_out[3:0]};
                endcase
            end
            rises++;
        end
    end

    // Data drive on falling serial clock.
    always @(negedge spi_sck) begin
        if (!spi_cs_n && rises >= pre_all() && (rises - pre_all()) < 8 / m_dl) begin
            automatic int k = rises - pre_all();
            automatic logic [7:0] b = mem(got_addr);
            case (m_dl)
                1: spi_io_in <= {2'b00, b[7 - k], 1'b0};
                2: spi_io_in <= {2'b00, b[7 - 2 * k -: 2]};
                default: spi_io_in <= (k == 0) ? b[7:4] : b[3:0];
            endcase
        end
    end

    always @(posedge spi_cs_n) sess_rises = rises;

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic read_addr(output logic [31:0] v);
        logic [7:0] b0, b1, b2, b3;
        bus_read(A_B0, b0);
        bus_read(A_B1, b1);
        bus_read(A_B2, b2);
        bus_read(A_B3, b3);
        v = {b3, b2, b1, b0};
    endtask

    task automatic write_addr(input logic [31:0] v);
        bus_write(A_B0, v[7:0]);
        bus_write(A_B1, v[15:8]);
        bus_write(A_B2, v[23:16]);
        bus_write(A_B3, v[31:24]);
    endtask

    task automatic wait_idle(output logic [7:0] d);
        int polls = 0;
        bus_read(A_CMD, d);
        while (d != 8'h00 && polls < 2000) begin
            bus_read(A_CMD, d);
            polls++;
        end
    endtask

    // One full read with all pin-level and register checks.
    task automatic do_read(input logic [31:0] sa, input logic [7:0] exp_op);
        logic [7:0] d;
        logic [31:0] sent, ra;
        int f0, exp_r;
        f0 = cs_falls;
        bus_write(A_CMD, 8'h81);
        bus_read(A_CMD, d);
        check(d == 8'h01, "R2 busy reads 0x01", d, 8'h01);
        wait_idle(d);
        check(d == 8'h00, "R2 busy clears", d, 8'h00);
        check(spi_cs_n == 1'b1, "R10 cs released", spi_cs_n, 1);
        check(cs_falls == f0 + 1, "R10 one frame per command", cs_falls, f0 + 1);
        sent = m_wide ? sa : {8'h00, sa[23:0]};
        check(got_op == exp_op, "R3 opcode", got_op, exp_op);
        check(got_addr == sent, "R4 R5 address bits", got_addr, sent);
        exp_r = pre_all() + 8 / m_dl;
        check(sess_rises == exp_r, "R6 clock count", sess_rises, exp_r);
        bus_read(A_RD, d);
        check(d == mem(sent), "R7 R8 data byte", d, mem(sent));
        read_addr(ra);
        check(ra == sa + 1, "R9 address advance", ra, sa + 1);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [31:0] a, ra;
        int f0;
        logic [7:0] ofs [10] = '{A_CMD, A_MODE, A_CFG, A_RD, A_B0, A_B1, A_B2, A_B3, A_OPA, A_OPB};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle pins and zeroed registers
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        check(spi_io_oe == 4'h0, "R1 oe", spi_io_oe, 0);
        foreach (ofs[i]) begin
            bus_read(ofs[i], d);
            check(d == 8'h00, "R1 register zero", d, 0);
        end

        // R2: other command values start nothing
        f0 = cs_falls;
        bus_write(A_CMD, 8'h80);
        bus_write(A_CMD, 8'h01);
        repeat (10) @(negedge clk);
        check(cs_falls == f0, "R2 bad command ignored", cs_falls, f0);
        bus_read(A_CMD, d);
        check(d == 8'h00, "R2 no busy after bad command", d, 0);

        // Sweep lane enables, address width and fast read.
        for (int c = 0; c < 64; c++) begin
            logic [7:0] opa, opb;
            opa = 8'h10 + 8'(c);
            opb = 8'hC0 + 8'(c);
            m_al   = c[3] ? 4 : (c[1] ? 2 : 1);
            m_dl   = c[2] ? 4 : (c[0] ? 2 : 1);
            m_wide = c[4];
            m_fast = c[5];
            bus_write(A_MODE, {3'b000, c[4:0]});
            bus_write(A_CFG, {7'b0, c[5]});
            bus_write(A_OPA, opa);
            bus_write(A_OPB, opb);
            a = {8'(c) ^ 8'h5A, 8'hA5, 8'h3C, 8'hFE};
            write_addr(a);
            do_read(a, c[2] ? opb : opa);
            do_read(a + 1, c[2] ? opb : opa);
        end

        // R9: 32-bit wrap
        m_al = 1; m_dl = 1; m_wide = 1; m_fast = 0;
        bus_write(A_MODE, 8'h10);
        bus_write(A_CFG, 8'h00);
        write_addr(32'hFFFF_FFFF);
        do_read(32'hFFFF_FFFF, 8'h10 + 8'd63);

        // R11 and R2: address writes and a second start while busy
        a = 32'h1234_5678;
        write_addr(a);
        f0 = cs_falls;
        bus_write(A_CMD, 8'h81);
        bus_write(A_B0, 8'h00);
        bus_write(A_B3, 8'h77);
        bus_write(A_CMD, 8'h81);
        wait_idle(d);
        check(got_addr == a, "R11 frame address unchanged", got_addr, a);
        read_addr(ra);
        check(ra == a + 1, "R11 address writes ignored while busy", ra, a + 1);
        repeat (10) @(negedge clk);
        check(cs_falls == f0 + 1, "R2 start while busy ignored", cs_falls, f0 + 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule